// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is a single configurable cell of a programmable logic array. It receives the sum-of-products result for the cell, a raw pin value, four shared clock lines, and two block-wide terms, one forcing low and one forcing high. A static configuration word chooses how the cell behaves. It can pass the sum straight through, store it in a D-type or T-type register, or hold it in a latch whose gate is active low. In buried use it can instead register or latch the pin value. An output polarity bit inverts the pin-facing output.

The cell always supplies a true-polarity feedback value for the routing fabric, whatever the mode. For test, a preload control writes the storage element directly, and an observe control brings the stored bit out. All behaviour is synchronous to one fabric clock `clk`. The four clock lines are sampled on `clk`. A register captures on the `clk` edge at which its selected line is first seen high. The force terms act on the outputs in the same cycle and on the stored bit at the next edge.

Configuration word layout (NUM_CLK = 4): bits [2:0] are the mode, bits [4:3] are the clock-line select, and bit 5 is the polarity. Mode codes are: 0 combinational, 1 D register, 2 T register, 3 latch, 4 input register (pin), 5 input latch (pin). Codes 6 and 7 act as combinational.

Top module: `macro_cell`

## Requirements
- R1: When `rstN` is low the stored bit is cleared to 0. After release in a storing mode, `fbOut` is 0 and `pinOut` equals polarity bit 5.
- R2: In mode 0, `fbOut` equals `sumTerm` in the same cycle, and `pinOut` equals `sumTerm` XOR bit 5.
- R3: In mode 1 the stored bit takes `sumTerm` at the `clk` edge where the selected clock line is high and was low at the previous edge. At all other edges it holds.
- R4: In mode 2, at a selected-line rising edge, the stored bit inverts when `sumTerm` is 1 and holds when it is 0.
- R5: Only the clock line indexed by bits [4:3] affects the cell. Edges on the other lines have no effect.
- R6: In mode 3, while the selected line is low, `fbOut` follows the data in the same cycle. While the line is high, `fbOut` holds the value taken at the last edge with the line low.
- R7: Polarity bit 5 inverts `pinOut` only. `fbOut` is never inverted.
- R8: In modes 1 to 5, `arTerm` forces `fbOut` to 0 at once and clears the stored bit at the next edge. `apTerm` does the same towards 1. `arTerm` wins when both are high. Neither term affects the output in combinational modes.
- R9: Modes 4 and 5 behave like modes 1 and 3 but take `pinIn` as data and ignore `sumTerm`.
- R10: With `preloadEn` high, the stored bit takes `preloadData` at the next edge, overriding any clock capture. When `arTerm` or `apTerm` is high at that edge, the preload is lost.
- R11: `obsOut` equals the stored bit while `observeEn` is high and is 0 otherwise.
- R12: Mode codes 6 and 7 behave as combinational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Active-low power-up clear |
| cfgWord | input | CFG_W (6) | Static configuration: mode, clock select, polarity |
| sumTerm | input | 1 | Sum-of-products result for this cell |
| pinIn | input | 1 | Pin value for input register/latch modes |
| clkLines | input | NUM_CLK (4) | Shared clock/gate lines |
| arTerm | input | 1 | Block-wide force-low term |
| apTerm | input | 1 | Block-wide force-high term |
| preloadEn | input | 1 | Test preload strobe |
| preloadData | input | 1 | Test preload value |
| observeEn | input | 1 | Test observe enable |
| pinOut | output | 1 | Polarity-adjusted output toward the pin |
| fbOut | output | 1 | True-polarity internal feedback |
| obsOut | output | 1 | Observed stored bit |

## Verification
A wrong stored bit shows on `fbOut` and `pinOut` in the first cycle after the faulty edge in register modes. In latch modes it stays hidden while the gate is low and appears once the gate rises. A stale clock-line history produces a capture one edge early or a missed capture, so the output lags or leads the expected sequence by one edge. A wrong override order shows at once on `fbOut` while a force term is high. It also shows on `obsOut` one edge later, so the bench reads the stored bit through the observe path whenever the outputs are masked.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_COMB    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_DREG    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_TREG    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_LATCH   = 3'd3;
  localparam logic [MODE_W-1:0] MODE_INREG   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_INLATCH = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;       // stored bit takes data this edge
    logic toggleEn;     // stored bit XORs with data this edge
    logic selPin;       // data comes from pin instead of sum
    logic transparent;  // latch open: output shows data directly
    logic combMode;     // output bypasses storage and overrides
  } cellStrobe_t;
endpackage

// File: rtl/macro_cell_ctrl.sv
module macro_cell_ctrl
  import macro_cell_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODE_W-1:0]  modeSel,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [NUM_CLK-1:0] clkLines,
  output cellStrobe_t        strobe
);
  logic [NUM_CLK-1:0] prevLines;
  logic [NUM_CLK-1:0] riseLines;
  logic               selLine;
  logic               selRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '0;
    else       prevLines <= clkLines;
  end

  // one rising-edge detector per shared line
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_rise
    assign riseLines[g] = clkLines[g] & ~prevLines[g];
  end

  assign selLine = clkLines[clkSel];
  assign selRise = riseLines[clkSel];

  always_comb begin
    strobe = '0;
    case (modeSel)
      MODE_DREG:  strobe.loadEn = selRise;
      MODE_TREG:  strobe.toggleEn = selRise;
      MODE_LATCH: begin
        strobe.loadEn      = ~selLine;
        strobe.transparent = ~selLine;
      end
      MODE_INREG: begin
        strobe.loadEn = selRise;
        strobe.selPin = 1'b1;
      end
      MODE_INLATCH: begin
        strobe.loadEn      = ~selLine;
        strobe.transparent = ~selLine;
        strobe.selPin      = 1'b1;
      end
      default: strobe.combMode = 1'b1;
    endcase
  end
endmodule

// File: rtl/macro_cell_dp.sv
module macro_cell_dp
  import macro_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cellStrobe_t strobe,
  input  logic        sumTerm,
  input  logic        pinIn,
  input  logic        arTerm,
  input  logic        apTerm,
  input  logic        preloadEn,
  input  logic        preloadData,
  input  logic        invert,
  input  logic        observeEn,
  output logic        pinOut,
  output logic        fbOut,
  output logic        obsOut,
  output logic        storedBit
);
  logic stateQ;
  logic stateD;
  logic dataIn;
  logic coreVal;

  assign dataIn = strobe.selPin ? pinIn : sumTerm;

  // force-low beats force-high beats preload beats clock action
  always_comb begin
    if (arTerm)               stateD = 1'b0;
    else if (apTerm)          stateD = 1'b1;
    else if (preloadEn)       stateD = preloadData;
    else if (strobe.toggleEn) stateD = stateQ ^ dataIn;
    else if (strobe.loadEn)   stateD = dataIn;
    else                      stateD = stateQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= 1'b0;
    else       stateQ <= stateD;
  end

  always_comb begin
    if (strobe.combMode)         coreVal = sumTerm;
    else if (arTerm)             coreVal = 1'b0;
    else if (apTerm)             coreVal = 1'b1;
    else if (strobe.transparent) coreVal = dataIn;
    else                         coreVal = stateQ;
  end

  assign fbOut     = coreVal;
  assign pinOut    = coreVal ^ invert;
  assign obsOut    = observeEn & stateQ;
  assign storedBit = stateQ;
endmodule

// File: rtl/macro_cell.sv
module macro_cell
  import macro_cell_pkg::*;
#(
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int CFG_W   = MODE_W + SEL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic               sumTerm,
  input  logic               pinIn,
  input  logic [NUM_CLK-1:0] clkLines,
  input  logic               arTerm,
  input  logic               apTerm,
  input  logic               preloadEn,
  input  logic               preloadData,
  input  logic               observeEn,
  output logic               pinOut,
  output logic               fbOut,
  output logic               obsOut
);
  cellStrobe_t strobe;
  logic        storedBit;

  macro_cell_ctrl #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (cfgWord[MODE_W-1:0]),
    .clkSel   (cfgWord[MODE_W +: SEL_W]),
    .clkLines (clkLines),
    .strobe   (strobe)
  );

  macro_cell_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sumTerm     (sumTerm),
    .pinIn       (pinIn),
    .arTerm      (arTerm),
    .apTerm      (apTerm),
    .preloadEn   (preloadEn),
    .preloadData (preloadData),
    .invert      (cfgWord[CFG_W-1]),
    .observeEn   (observeEn),
    .pinOut      (pinOut),
    .fbOut       (fbOut),
    .obsOut      (obsOut),
    .storedBit   (storedBit)
  );
endmodule

// File: rtl/macro_cell_chk.sv
module macro_cell_chk #(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = 2,
  parameter int CFG_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [CFG_W-1:0]   cfgWord,
  input logic               sumTerm,
  input logic [NUM_CLK-1:0] clkLines,
  input logic               arTerm,
  input logic               apTerm,
  input logic               preloadEn,
  input logic               preloadData,
  input logic               observeEn,
  input logic               fbOut,
  input logic               obsOut,
  input logic               storedBit
);
  logic [2:0] modeBits;
  logic       selBit;
  logic       nonComb;
  logic       quiet;

  assign modeBits = cfgWord[2:0];
  assign selBit   = clkLines[cfgWord[3 +: SEL_W]];
  assign nonComb  = (modeBits >= 3'd1) && (modeBits <= 3'd5);
  assign quiet    = !arTerm && !apTerm && !preloadEn;

  p_ar_forces_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    nonComb && arTerm |-> !fbOut);

  p_ap_forces_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    nonComb && !arTerm && apTerm |-> fbOut);

  p_ar_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    arTerm |=> !storedBit);

  p_comb_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    !nonComb |-> fbOut == sumTerm);

  p_dreg_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeBits == 3'd1 && !selBit && quiet |=> $stable(storedBit));

  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeBits == 3'd2 && selBit && !$past(selBit) && sumTerm && quiet
    |=> storedBit != $past(storedBit));

  p_latch_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    modeBits == 3'd3 && !selBit && !arTerm && !apTerm |-> fbOut == sumTerm);

  p_preload_r10: assert property (@(posedge clk) disable iff (!rstN)
    preloadEn && !arTerm && !apTerm |=> storedBit == $past(preloadData));

  p_observe_r11: assert property (@(posedge clk) disable iff (!rstN)
    observeEn |-> obsOut == storedBit);
endmodule

bind macro_cell macro_cell_chk #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W), .CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgWord     (cfgWord),
  .sumTerm     (sumTerm),
  .clkLines    (clkLines),
  .arTerm      (arTerm),
  .apTerm      (apTerm),
  .preloadEn   (preloadEn),
  .preloadData (preloadData),
  .observeEn   (observeEn),
  .fbOut       (fbOut),
  .obsOut      (obsOut),
  .storedBit   (storedBit)
);

// File: tb/tb_macro_cell.sv
`timescale 1ns/1ps
module tb_macro_cell;
  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] cfgWord;
  logic       sumTerm, pinIn, arTerm, apTerm;
  logic [3:0] clkLines;
  logic       preloadEn, preloadData, observeEn;
  logic       pinOut, fbOut, obsOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  macro_cell dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .sumTerm(sumTerm), .pinIn(pinIn),
    .clkLines(clkLines), .arTerm(arTerm), .apTerm(apTerm), .preloadEn(preloadEn),
    .preloadData(preloadData), .observeEn(observeEn),
    .pinOut(pinOut), .fbOut(fbOut), .obsOut(obsOut)
  );

  // {cfg[5:0], sum, pin, line0, ar, ap, expPin, expFb}
  localparam int NVEC = 25;
  localparam logic [12:0] VEC [NVEC] = '{
    13'b000000_1_0_0_0_0_1_1,
    13'b100000_1_0_0_0_0_0_1,
    13'b000000_0_0_0_1_0_0_0,
    13'b000000_1_0_0_1_1_1_1,
    13'b000001_1_0_0_0_0_0_0,
    13'b000001_1_0_1_0_0_1_1,
    13'b000001_0_0_1_0_0_1_1,
    13'b000001_0_0_0_0_0_1_1,
    13'b000001_0_0_1_0_0_0_0,
    13'b100001_1_0_0_0_0_1_0,
    13'b000001_0_0_0_0_1_1_1,
    13'b000001_0_0_0_0_0_1_1,
    13'b000001_0_0_0_1_1_0_0,
    13'b000010_1_0_0_0_0_0_0,
    13'b000010_1_0_1_0_0_1_1,
    13'b000010_1_0_0_0_0_1_1,
    13'b000010_0_0_1_0_0_1_1,
    13'b000010_0_0_0_0_0_1_1,
    13'b000010_1_0_1_0_0_0_0,
    13'b000100_1_0_0_0_0_0_0,
    13'b000100_1_0_1_0_0_0_0,
    13'b000100_0_1_0_0_0_0_0,
    13'b000100_0_1_1_0_0_1_1,
    13'b000110_0_0_0_0_0_0_0,
    13'b000111_1_0_0_0_0_1_1
  };

  function automatic string reqOf(int i);
    if (i < 3)  return "R2";
    if (i < 4)  return "R8";
    if (i < 9)  return "R3";
    if (i < 10) return "R7";
    if (i < 13) return "R8";
    if (i < 19) return "R4";
    if (i < 23) return "R9";
    return "R12";
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearCell();
    arTerm = 1'b1;
    step();
    arTerm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWord = 6'b100001; sumTerm = 1'b1; pinIn = 1'b0;
    clkLines = 4'b0; arTerm = 1'b0; apTerm = 1'b0;
    preloadEn = 1'b0; preloadData = 1'b0; observeEn = 1'b1;
    repeat (3) step();
    rstN = 1'b1;
    #1;
    // R1: cleared storage, pin level set by polarity alone
    check("R1", "pinOut after reset", pinOut, 1'b1);
    check("R1", "fbOut after reset", fbOut, 1'b0);
    check("R1", "obsOut after reset", obsOut, 1'b0);
    observeEn = 1'b0;

    // vector walk
    for (int i = 0; i < NVEC; i++) begin
      cfgWord  = VEC[i][12:7];
      sumTerm  = VEC[i][6];
      pinIn    = VEC[i][5];
      clkLines = {3'b000, VEC[i][4]};
      arTerm   = VEC[i][3];
      apTerm   = VEC[i][2];
      step();
      check(reqOf(i), $sformatf("vec %0d pinOut", i), pinOut, VEC[i][1]);
      check(reqOf(i), $sformatf("vec %0d fbOut", i), fbOut, VEC[i][0]);
    end
    clkLines = 4'b0; arTerm = 1'b0; apTerm = 1'b0;

    // R5: only line 2 is selected
    cfgWord = 6'b010001;
    clearCell();
    sumTerm = 1'b1; clkLines = 4'b1011;
    step();
    check("R5", "unselected edges", fbOut, 1'b0);
    clkLines = 4'b0000; step();
    clkLines = 4'b0100; step();
    check("R5", "selected edge", fbOut, 1'b1);
    clkLines = 4'b0000;

    // R6: latch on line 1, gate low transparent
    cfgWord = 6'b001011;
    clearCell();
    sumTerm = 1'b1; step();
    check("R6", "transparent high", fbOut, 1'b1);
    sumTerm = 1'b0; step();
    check("R6", "transparent low", fbOut, 1'b0);
    sumTerm = 1'b1; step();
    clkLines = 4'b0010; sumTerm = 1'b0; step();
    check("R6", "held while gate high", fbOut, 1'b1);
    clkLines = 4'b0000; step();
    check("R6", "reopened", fbOut, 1'b0);

    // R9: input latch takes pin, ignores sum
    cfgWord = 6'b001101;
    pinIn = 1'b1; sumTerm = 1'b0; step();
    check("R9", "input latch pin high", fbOut, 1'b1);
    pinIn = 1'b0; sumTerm = 1'b1; step();
    check("R9", "input latch pin low", fbOut, 1'b0);
    pinIn = 1'b1; step();
    clkLines = 4'b0010; pinIn = 1'b0; step();
    check("R9", "input latch hold", fbOut, 1'b1);
    clkLines = 4'b0000;

    // R10: preload overrides a capture edge
    cfgWord = 6'b000001;
    clearCell();
    sumTerm = 1'b0; preloadEn = 1'b1; preloadData = 1'b1; clkLines = 4'b0001;
    step();
    preloadEn = 1'b0; clkLines = 4'b0000; observeEn = 1'b1;
    #1;
    check("R10", "preload beats capture", obsOut, 1'b1);
    check("R10", "preload on fbOut", fbOut, 1'b1);
    // R11: observe disabled hides the stored 1
    observeEn = 1'b0;
    #1;
    check("R11", "observe off", obsOut, 1'b0);
    // R10: preload lost under force-low
    preloadEn = 1'b1; preloadData = 1'b1; arTerm = 1'b1;
    step();
    preloadEn = 1'b0; arTerm = 1'b0; observeEn = 1'b1;
    #1;
    check("R10", "preload lost to force-low", obsOut, 1'b0);
    // R10: preload lost under force-high
    preloadData = 1'b0; preloadEn = 1'b1; apTerm = 1'b1;
    step();
    preloadEn = 1'b0; apTerm = 1'b0;
    #1;
    check("R10", "preload lost to force-high", obsOut, 1'b1);
    check("R11", "observe on", obsOut, fbOut);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule